// File: doc/BRIEF.md
# Rank-Weighted Elitist Breeding Planner

This block turns a table of fitness scores for a 30-member population into the breeding plan for the next generation. Software or a neighbouring engine writes one fitness value per individual while the block is idle and then pulses `start`. The block ranks the individuals from best to worst, drops the five weakest, and gives each of the 25 survivors a selection weight that falls linearly with rank. Weights are held as integers scaled by 24, so rank r carries 480 - 19*r (480 for the best, 24 for the worst, 6300 in total).

After ranking, the block emits 30 child descriptors, one per slot of the next generation, over a valid/ready stream. Slot 0 is always the unchanged copy of the best individual. Every other slot names two parents chosen by roulette over the survivor weights. It also carries a crossover decision, taken with 70 % probability, and a cut position inside the 2424-bit genotype. All random draws come from an internal 16-bit LFSR that is seeded at `start`, so a given seed and fitness table always give the same plan.

Top module: `breed_planner`

## Requirements
- R1: After reset, `busy` and `ch_valid` are low.
- R2: While idle, a write with `fit_we` high stores `fit_val` as the fitness of individual `fit_idx`; indices of 30 or more are dropped. Writes made while `busy` is high are ignored and do not change the table used by later runs.
- R3: A `start` pulse while idle loads the LFSR with `seed`, or with 1 when `seed` is zero, and raises `busy` in the next cycle. A `start` pulse while `busy` is high is ignored.
- R4: Individuals are ranked by fitness, highest first. Of two equal fitness values, the lower index ranks higher. Ranks 25 to 29 are culled.
- R5: Child 0 is the elite copy: `ch_elite`=1, both parents are the rank-0 individual, `ch_xover`=0, `ch_cut`=0, and no LFSR draw is used.
- R6: The LFSR steps as s' = (s >> 1) XOR (s[0] ? 0xB400 : 0). Each non-elite child takes four successive steps v1..v4. v1 selects parent A, v2 selects parent B, v3 decides crossover and v4 sets the cut.
- R7: A parent pick takes t = v mod 6300 and chooses the smallest rank r whose running weight sum, over ranks 0..r of 480 - 19*k, exceeds t. The parent emitted is the index of the individual at that rank. Culled ranks are never chosen.
- R8: Crossover is on when (v3 mod 100) < 70. The cut is then 1 + (v4 mod 2423). When crossover is off, the cut is 0.
- R9: Children are numbered 0 to 29 on `ch_num` and sent in that order. A descriptor stays valid and unchanged until `ch_ready` takes it. After child 29 is taken, `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fit_we | input | 1 | Fitness write strobe |
| fit_idx | input | 5 | Individual addressed by the write |
| fit_val | input | 16 | Fitness value written |
| seed | input | 16 | LFSR seed taken at start |
| start | input | 1 | Begin one generation's plan |
| busy | output | 1 | Ranking or emitting in progress |
| ch_valid | output | 1 | Child descriptor present |
| ch_ready | input | 1 | Consumer takes the descriptor |
| ch_num | output | 5 | Child slot number |
| ch_elite | output | 1 | Slot is the unmutated elite copy |
| ch_par_a | output | 5 | First parent index |
| ch_par_b | output | 5 | Second parent index |
| ch_xover | output | 1 | Apply single-point crossover |
| ch_cut | output | 12 | Crossover bit position |

## Verification
The bench rebuilds the ranking, the LFSR walk and the roulette scan on its own and compares every descriptor of several generations. An all-equal fitness table exposes tie handling: a design that broke ties toward the higher index would pick a different elite and shift every parent. Runs with zero and all-ones seeds, and with rankings in both directions, reach the first and last survivor bands. If a culled rank leaked into the roulette, or an off-by-one crept into the running sum, parent indices would move at those band edges. During one run the bench pulses `start` and rewrites a fitness entry mid-stream, then runs again without reloading the table. A design that honoured either action would reseed or re-rank, and the descriptors of that run or the next would diverge. Random stalls on `ch_ready` catch any descriptor that advances without being taken.

// File: rtl/brd_pkg.sv
package brd_pkg;

    localparam int RNDW = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RANK  = 2'd1,
        ST_BUILD = 2'd2,
        ST_SHOW  = 2'd3
    } brd_state_e;

    // one step of a right-shifting Galois LFSR
    function automatic logic [RNDW-1:0] rnd_step(input logic [RNDW-1:0] s,
                                                 input logic [RNDW-1:0] taps);
        rnd_step = (s >> 1) ^ (s[0] ? taps : '0);
    endfunction

    // scaled weight of rank r: top weight times (surv-1) falling linearly
    function automatic int rank_weight(input int r, input int surv,
                                       input int wtop, input int wbot);
        return wtop * (surv - 1) - (wtop - wbot) * r;
    endfunction

    // running weight sum over ranks 0..r
    function automatic int cum_weight(input int r, input int surv,
                                      input int wtop, input int wbot);
        int acc;
        acc = 0;
        for (int k = 0; k <= r; k++) acc += rank_weight(k, surv, wtop, wbot);
        return acc;
    endfunction

endpackage

// File: rtl/brd_rank_count.sv
module brd_rank_count #(
    parameter int POP = 30,
    parameter int FW  = 16,
    parameter int IW  = $clog2(POP)
) (
    input  logic [FW-1:0] fit [POP],
    input  logic [IW-1:0] who,
    output logic [IW-1:0] rank
);

    logic [FW-1:0] mine;
    logic [IW-1:0] beaten_by;

    // rank = number of entries that outrank "who"; lower index wins ties
    always_comb begin
        mine      = fit[who];
        beaten_by = '0;
        for (int j = 0; j < POP; j++) begin
            if ((fit[j] > mine) || ((fit[j] == mine) && (IW'(j) < who)))
                beaten_by = beaten_by + IW'(1);
        end
        rank = beaten_by;
    end

endmodule

// File: rtl/brd_roulette.sv
module brd_roulette
    import brd_pkg::*;
#(
    parameter int POP   = 30,
    parameter int SURV  = 25,
    parameter int W_TOP = 20,
    parameter int W_BOT = 1,
    parameter int IW    = $clog2(POP)
) (
    input  logic [RNDW-1:0] rnd,
    input  logic [IW-1:0]   order [POP],
    output logic [IW-1:0]   pick
);

    localparam int TOTAL = cum_weight(SURV - 1, SURV, W_TOP, W_BOT);

    logic [RNDW-1:0] tgt;
    logic [IW-1:0]   hit_rank;
    logic            hit;

    always_comb begin
        tgt      = rnd % RNDW'(TOTAL);
        hit      = 1'b0;
        hit_rank = IW'(SURV - 1);
        for (int r = 0; r < SURV; r++) begin
            if (!hit && (int'(tgt) < cum_weight(r, SURV, W_TOP, W_BOT))) begin
                hit      = 1'b1;
                hit_rank = IW'(r);
            end
        end
        pick = order[hit_rank];
    end

endmodule

// File: rtl/breed_planner.sv
module breed_planner
    import brd_pkg::*;
#(
    parameter int              POP    = 30,
    parameter int              CULL   = 5,
    parameter int              FW     = 16,
    parameter int              W_TOP  = 20,
    parameter int              W_BOT  = 1,
    parameter int              SEG_N  = 101,
    parameter int              SEG_W  = 24,
    parameter int              XO_PCT = 70,
    parameter logic [RNDW-1:0] TAPS   = 16'hB400,
    parameter int              IW     = $clog2(POP),
    parameter int              CW     = $clog2(SEG_N * SEG_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fit_we,
    input  logic [IW-1:0]   fit_idx,
    input  logic [FW-1:0]   fit_val,
    input  logic [RNDW-1:0] seed,
    input  logic            start,
    output logic            busy,
    output logic            ch_valid,
    input  logic            ch_ready,
    output logic [IW-1:0]   ch_num,
    output logic            ch_elite,
    output logic [IW-1:0]   ch_par_a,
    output logic [IW-1:0]   ch_par_b,
    output logic            ch_xover,
    output logic [CW-1:0]   ch_cut
);

    localparam int SURV  = POP - CULL;
    localparam int GBITS = SEG_N * SEG_W;
    localparam int NDRAW = 4;
    localparam int PCT   = 100;

    typedef struct packed {
        brd_state_e      st;
        logic [IW-1:0]   cnt;
        logic [RNDW-1:0] lfsr;
        logic [IW-1:0]   child;
        logic            valid;
        logic            elite;
        logic [IW-1:0]   pa;
        logic [IW-1:0]   pb;
        logic            xo;
        logic [CW-1:0]   cut;
    } ctl_t;

    ctl_t          c_d, c_q;
    logic [FW-1:0] fit_d   [POP];
    logic [FW-1:0] fit_q   [POP];
    logic [IW-1:0] order_d [POP];
    logic [IW-1:0] order_q [POP];

    logic [IW-1:0]   rank_w;
    logic [RNDW-1:0] draw [NDRAW];
    logic [IW-1:0]   pick [2];
    logic            coin;
    logic [CW-1:0]   cut_pt;

    // ---------------- ranking: one individual per cycle ----------------
    brd_rank_count #(.POP(POP), .FW(FW), .IW(IW)) u_rank (
        .fit  (fit_q),
        .who  (c_q.cnt),
        .rank (rank_w)
    );

    // ---------------- four chained LFSR steps per child ----------------
    always_comb begin
        draw[0] = rnd_step(c_q.lfsr, TAPS);
        for (int k = 1; k < NDRAW; k++) draw[k] = rnd_step(draw[k-1], TAPS);
    end

    // ---------------- two roulette pickers ----------------
    for (genvar g = 0; g < 2; g++) begin : g_pick
        brd_roulette #(
            .POP(POP), .SURV(SURV), .W_TOP(W_TOP), .W_BOT(W_BOT), .IW(IW)
        ) u_wheel (
            .rnd   (draw[g]),
            .order (order_q),
            .pick  (pick[g])
        );
    end

    always_comb begin
        coin   = (draw[2] % RNDW'(PCT)) < RNDW'(XO_PCT);
        cut_pt = CW'(draw[3] % RNDW'(GBITS - 1)) + CW'(1);
    end

    // ---------------- next-state ----------------
    always_comb begin
        c_d     = c_q;
        fit_d   = fit_q;
        order_d = order_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (fit_we && (int'(fit_idx) < POP)) fit_d[fit_idx] = fit_val;
                if (start) begin
                    c_d.lfsr = (seed == '0) ? RNDW'(1) : seed;
                    c_d.cnt  = '0;
                    c_d.st   = ST_RANK;
                end
            end
            ST_RANK: begin
                order_d[rank_w] = c_q.cnt;
                if (c_q.cnt == IW'(POP - 1)) begin
                    c_d.child = '0;
                    c_d.st    = ST_BUILD;
                end else begin
                    c_d.cnt = c_q.cnt + IW'(1);
                end
            end
            ST_BUILD: begin
                if (c_q.child == '0) begin
                    c_d.elite = 1'b1;
                    c_d.pa    = order_q[0];
                    c_d.pb    = order_q[0];
                    c_d.xo    = 1'b0;
                    c_d.cut   = '0;
                end else begin
                    c_d.elite = 1'b0;
                    c_d.pa    = pick[0];
                    c_d.pb    = pick[1];
                    c_d.xo    = coin;
                    c_d.cut   = coin ? cut_pt : '0;
                    c_d.lfsr  = draw[NDRAW-1];
                end
                c_d.valid = 1'b1;
                c_d.st    = ST_SHOW;
            end
            ST_SHOW: begin
                if (ch_ready) begin
                    c_d.valid = 1'b0;
                    if (c_q.child == IW'(POP - 1)) begin
                        c_d.st = ST_IDLE;
                    end else begin
                        c_d.child = c_q.child + IW'(1);
                        c_d.st    = ST_BUILD;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
            for (int i = 0; i < POP; i++) begin
                fit_q[i]   <= '0;
                order_q[i] <= '0;
            end
        end else begin
            c_q     <= c_d;
            fit_q   <= fit_d;
            order_q <= order_d;
        end
    end

    assign busy     = (c_q.st != ST_IDLE);
    assign ch_valid = c_q.valid;
    assign ch_num   = c_q.child;
    assign ch_elite = c_q.elite;
    assign ch_par_a = c_q.pa;
    assign ch_par_b = c_q.pb;
    assign ch_xover = c_q.xo;
    assign ch_cut   = c_q.cut;

    // ---------------- assertions ----------------
    AST_DESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid && !ch_ready |=> ch_valid &&
        $stable({ch_num, ch_elite, ch_par_a, ch_par_b, ch_xover, ch_cut})); // R9
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ch_valid); // R9
    AST_CUT_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid && ch_xover |-> (ch_cut != '0) && (int'(ch_cut) < GBITS)); // R8
    AST_CUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid && !ch_xover |-> ch_cut == '0); // R8
    AST_ELITE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> (ch_elite == (ch_num == '0))); // R5
    AST_ELITE_CLONE: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid && ch_elite |-> (ch_par_a == ch_par_b) && !ch_xover); // R5
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy); // R3
    AST_PARENT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> (int'(ch_par_a) < POP) && (int'(ch_par_b) < POP)); // R7

endmodule

// File: tb/sim_breed_planner.sv
module sim_breed_planner;

    localparam int POP   = 30;
    localparam int SURV  = 25;
    localparam int TOTAL = 6300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fit_we = 1'b0;
    logic [4:0]  fit_idx = '0;
    logic [15:0] fit_val = '0;
    logic [15:0] seed = '0;
    logic        start = 1'b0;
    logic        busy;
    logic        ch_valid;
    logic        ch_ready = 1'b0;
    logic [4:0]  ch_num;
    logic        ch_elite;
    logic [4:0]  ch_par_a;
    logic [4:0]  ch_par_b;
    logic        ch_xover;
    logic [11:0] ch_cut;

    int total = 0;
    int bad   = 0;
    int tab [POP];

    always #5 clk = ~clk;

    breed_planner u0 (
        .clk(clk), .rst_n(rst_n), .fit_we(fit_we), .fit_idx(fit_idx),
        .fit_val(fit_val), .seed(seed), .start(start), .busy(busy),
        .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_num(ch_num),
        .ch_elite(ch_elite), .ch_par_a(ch_par_a), .ch_par_b(ch_par_b),
        .ch_xover(ch_xover), .ch_cut(ch_cut)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic logic [15:0] nx(input logic [15:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    function automatic int wheel(input logic [15:0] v, input int ord[POP]);
        int t, acc;
        t = int'(v) % TOTAL;
        acc = 0;
        for (int r = 0; r < SURV; r++) begin
            acc += 480 - 19 * r;
            if (t < acc) return ord[r];
        end
        return -1;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_table();
        for (int i = 0; i < POP; i++) begin
            fit_we = 1'b1; fit_idx = 5'(i); fit_val = 16'(tab[i]);
            tick();
        end
        fit_we = 1'b0;
    endtask

    task automatic run_gen(input logic [15:0] sd, input bit poke);
        int ord[POP];
        bit used[POP];
        int e_pa[POP], e_pb[POP], e_xo[POP], e_cut[POP];
        logic [15:0] s, v1, v2, v3, v4;
        int c, k;
        bit did_start, did_write;
        // R4: best first, lower index on ties
        for (int i = 0; i < POP; i++) used[i] = 1'b0;
        for (int r = 0; r < POP; r++) begin
            int best;
            best = -1;
            for (int i = 0; i < POP; i++)
                if (!used[i] && (best < 0 || tab[i] > tab[best])) best = i;
            ord[r] = best;
            used[best] = 1'b1;
        end
        s = (sd == 16'h0) ? 16'h0001 : sd;  // R3
        e_pa[0] = ord[0]; e_pb[0] = ord[0]; e_xo[0] = 0; e_cut[0] = 0;
        for (int ch = 1; ch < POP; ch++) begin  // R6 draw order
            v1 = nx(s); v2 = nx(v1); v3 = nx(v2); v4 = nx(v3); s = v4;
            e_pa[ch] = wheel(v1, ord);
            e_pb[ch] = wheel(v2, ord);
            e_xo[ch] = ((int'(v3) % 100) < 70) ? 1 : 0;
            e_cut[ch] = e_xo[ch] ? 1 + (int'(v4) % 2423) : 0;
        end
        seed = sd; start = 1'b1;
        tick();
        start = 1'b0;
        check(busy == 1'b1, "R3 busy after start", int'(busy), 1);
        c = 0; k = 0; did_start = 1'b0; did_write = 1'b0;
        while (c < POP && k < 4000) begin
            ch_ready = ((k % 3) != 1) || (k > 3000);
            start = 1'b0; fit_we = 1'b0;
            if (poke && c == 10 && !did_start) begin
                start = 1'b1; seed = 16'h5A5A; did_start = 1'b1;  // R3 ignored
            end
            if (poke && c == 12 && !did_write) begin
                fit_we = 1'b1; fit_idx = 5'd29; fit_val = 16'hEA60; did_write = 1'b1;  // R2 ignored
            end
            if (ch_valid && ch_ready) begin
                check(int'(ch_num) == c, "R9 child number", int'(ch_num), c);
                if (c == 0) begin
                    check(ch_elite == 1'b1 && int'(ch_par_a) == e_pa[0] && int'(ch_par_b) == e_pb[0]
                          && !ch_xover && ch_cut == '0, "R5 elite slot",
                          int'(ch_par_a), e_pa[0]);
                end else begin
                    check(!ch_elite, "R5 elite flag clear", int'(ch_elite), 0);
                    check(int'(ch_par_a) == e_pa[c], "R7 parent A", int'(ch_par_a), e_pa[c]);
                    check(int'(ch_par_b) == e_pb[c], "R7 parent B", int'(ch_par_b), e_pb[c]);
                    check(int'(ch_xover) == e_xo[c], "R8 crossover", int'(ch_xover), e_xo[c]);
                    check(int'(ch_cut) == e_cut[c], "R8 cut", int'(ch_cut), e_cut[c]);
                end
                c++;
            end
            tick();
            k++;
        end
        ch_ready = 1'b0; start = 1'b0; fit_we = 1'b0;
        check(c == POP, "R9 all children delivered", c, POP);
        check(!busy && !ch_valid, "R9 idle after last child", int'(busy), 0);
    endtask

    initial begin
        #(20000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog expired got=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(); tick();
        check(!busy && !ch_valid, "R1 reset outputs", int'(busy) + int'(ch_valid), 0);
        rst_n = 1'b1;
        tick();
        check(!busy && !ch_valid, "R1 idle after reset", int'(busy) + int'(ch_valid), 0);

        // distinct scrambled fitness (R2 writes, R4 ranking)
        for (int i = 0; i < POP; i++) tab[i] = (i * 1237 + 91) % 4096;
        load_table();
        fit_we = 1'b1; fit_idx = 5'd31; fit_val = 16'hFFFF;  // R2 out-of-range index dropped
        tick();
        fit_we = 1'b0;
        run_gen(16'hACE1, 1'b0);

        // all equal: ties resolved toward lower index (R4), zero seed (R3)
        for (int i = 0; i < POP; i++) tab[i] = 500;
        load_table();
        run_gen(16'h0000, 1'b0);

        // descending, with ignored start and write mid-run (R2, R3)
        for (int i = 0; i < POP; i++) tab[i] = 1000 - 3 * i;
        load_table();
        run_gen(16'h1234, 1'b1);

        // table must be unchanged by the mid-run write (R2)
        run_gen(16'h0BAD, 1'b0);

        // ascending with duplicates, all-ones seed (R4, R7)
        for (int i = 0; i < POP; i++) tab[i] = i / 3;
        load_table();
        run_gen(16'hFFFF, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule